// File: doc/BRIEF.md
# Shadow-Latch Timing-Error Detecting Register Bank

This block is a register bank of `WIDTH` bits for logic that runs at a reduced supply voltage. Each bit has a main flip-flop that captures its input early, on the rising edge of `clk`. Beside it sits a shadow latch that samples the same input later, while a delayed clock `clk_del` is high. The environment supplies `clk_del`, about half a period behind `clk`. If data arrives late, the two copies disagree. That disagreement is treated as a setup violation.

Data enters through a valid/ready port. An item transfers on a rising `clk` edge where `in_valid` and `in_ready` are both high. Rules for the producer:
- While `in_valid` is high and `in_ready` is low, the producer must keep `in_data` steady and keep `in_valid` high.
- `in_ready` depends only on bank state, never on `in_valid`.
- `in_ready` drops for exactly one cycle when a violation is pending. On that edge the bank replaces its main value with the shadow value, which is the stall-and-replay step.

`err` pulses for one cycle per violation. A saturating counter totals the pulses. `q_safe` shows the shadow value while a violation is pending, so a consumer can restore the correct data before the correction edge.

Top module: `shadow_err_bank`

## Requirements
- R1: An item transfers on a rising `clk` edge where `in_valid` and `in_ready` are both high. After that edge, `q` equals the transferred `in_data`.
- R2: While `in_valid` is low, `q` holds its value and `err` stays 0, however `in_data` moves.
- R3: If `in_data` stays stable from before the capturing edge until `clk_del` falls, no violation is raised. `err` stays 0 and `err_count` does not change.
- R4: If `in_data` changes after the capturing edge while the shadow latch is still open, a violation is raised. On the next rising edge, `err` goes high for exactly one cycle.
- R5: While a violation is pending (before the correction edge), `q_safe` equals the late-sampled shadow value. At all other times `q_safe` equals `q`.
- R6: `in_ready` is low during the single cycle in which a violation is pending, so no item transfers on the correction edge. In the following cycle `in_ready` is high again.
- R7: On the correction edge, `q` is loaded with the shadow value. After it, `q` equals the value `q_safe` showed.
- R8: `err_count` increases by one with each `err` pulse. It stops at 2^`CNT_W`-1.
- R9: A synchronous active-high `rst` clears `q`, every shadow latch, `err` and `err_count` to 0. After reset, `q_safe` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main capture clock |
| clk_del | input | 1 | Delayed clock; shadow latches are open while high |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Producer offers `in_data` |
| in_ready | output | 1 | Bank takes an item on this edge; low only while a violation is pending |
| in_data | input | WIDTH | Data to register |
| q | output | WIDTH | Registered (speculative, then corrected) value |
| q_safe | output | WIDTH | Shadow value while a violation is pending, else `q` |
| err | output | 1 | One-cycle pulse per detected violation |
| err_count | output | CNT_W | Saturating count of `err` pulses |

## Verification
A shadow latch left open, or one that never opens, shows at the ports one cycle after capture:
- An open latch produces an `err` pulse for data that was held steady.
- A latch that never opens misses a late change, so `q` never moves to the late value.

A lost correction shows one edge later: `q` differs from the `q_safe` value read just before. A wrong ready rule shows in the same place. Either `in_ready` fails to drop the cycle before `err`, or the held item is taken twice, or it is taken during the stall.

Sweeping every data value, both settled and with a late change, reaches each bit in both directions. The sweep also drives the narrow counter into saturation.

// File: rtl/shadow_err_pkg.sv
package shadow_err_pkg;
  localparam int unsigned BANK_W_DFLT = 16;
  localparam int unsigned TALLY_W_DFLT = 16;

  // Control view of one cycle: whether a capture is under check and
  // whether that check found a disagreement.
  typedef struct packed {
    logic armed;
    logic viol;
  } chk_state_t;
endpackage

// File: rtl/shadow_bit_cell.sv
module shadow_bit_cell (
  input  logic clk,
  input  logic clk_del,
  input  logic rst,
  input  logic load,
  input  logic fix,
  input  logic arm,
  input  logic d,
  output logic q,
  output logic shadow,
  output logic mismatch
);
  // Main flip-flop: speculative capture, or reload from the shadow copy.
  always_ff @(posedge clk) begin
    if (rst)       q <= 1'b0;
    else if (fix)  q <= shadow;
    else if (load) q <= d;
  end

  // Shadow latch: open while the delayed clock is high, but only for a
  // cycle that follows a real capture, so idle cycles cannot diverge.
  always_latch begin
    if (rst)                 shadow <= 1'b0;
    else if (clk_del && arm) shadow <= d;
  end

  assign mismatch = q ^ shadow;
endmodule

// File: rtl/shadow_err_ctl.sv
module shadow_err_ctl
  import shadow_err_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic in_valid,
  input  logic any_mismatch,
  output logic in_ready,
  output logic accept,
  output logic fix,
  output logic arm,
  output logic err
);
  chk_state_t st_q;
  logic       viol_now;

  // A disagreement counts only when the previous edge captured new data.
  assign viol_now = st_q.armed & any_mismatch;
  assign in_ready = ~viol_now;
  assign accept   = in_valid & in_ready;
  assign fix      = viol_now;
  assign arm      = st_q.armed;
  assign err      = st_q.viol;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q <= '0;
    end else begin
      st_q.armed <= accept;
      st_q.viol  <= viol_now;
    end
  end
endmodule

// File: rtl/shadow_err_tally.sv
module shadow_err_tally #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bump,
  output logic [CNT_W-1:0] count
);
  localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

  always_ff @(posedge clk) begin
    if (rst)                        count <= '0;
    else if (bump && (count != TOP)) count <= count + 1'b1;
  end
endmodule

// File: rtl/shadow_err_bank.sv
module shadow_err_bank
  import shadow_err_pkg::*;
#(
  parameter int unsigned WIDTH = BANK_W_DFLT,
  parameter int unsigned CNT_W = TALLY_W_DFLT
) (
  input  logic             clk,
  input  logic             clk_del,
  input  logic             rst,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [WIDTH-1:0] in_data,
  output logic [WIDTH-1:0] q,
  output logic [WIDTH-1:0] q_safe,
  output logic             err,
  output logic [CNT_W-1:0] err_count
);
  logic [WIDTH-1:0] shadow_v;
  logic [WIDTH-1:0] miss_v;
  logic             accept;
  logic             fix;
  logic             arm;

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    shadow_bit_cell u_cell (
      .clk      (clk),
      .clk_del  (clk_del),
      .rst      (rst),
      .load     (accept),
      .fix      (fix),
      .arm      (arm),
      .d        (in_data[b]),
      .q        (q[b]),
      .shadow   (shadow_v[b]),
      .mismatch (miss_v[b])
    );
  end

  shadow_err_ctl u_ctl (
    .clk          (clk),
    .rst          (rst),
    .in_valid     (in_valid),
    .any_mismatch (|miss_v),
    .in_ready     (in_ready),
    .accept       (accept),
    .fix          (fix),
    .arm          (arm),
    .err          (err)
  );

  shadow_err_tally #(.CNT_W(CNT_W)) u_tally (
    .clk   (clk),
    .rst   (rst),
    .bump  (fix),
    .count (err_count)
  );

  assign q_safe = fix ? shadow_v : q;
endmodule

// File: rtl/shadow_err_bank_chk.sv
module shadow_err_bank_chk #(
  parameter int unsigned WIDTH = 16,
  parameter int unsigned CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic             in_ready,
  input logic [WIDTH-1:0] q,
  input logic [WIDTH-1:0] q_safe,
  input logic             err,
  input logic [CNT_W-1:0] err_count
);
  localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

  assert_pulse_one_cycle_R4: assert property (@(posedge clk) disable iff (rst)
    err |=> !err);

  assert_stall_then_err_R6: assert property (@(posedge clk) disable iff (rst)
    !in_ready |=> err);

  assert_ready_back_R6: assert property (@(posedge clk) disable iff (rst)
    err |-> in_ready);

  assert_idle_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (!in_valid && in_ready) |=> $stable(q));

  assert_correct_value_R7: assert property (@(posedge clk) disable iff (rst)
    !in_ready |=> (q == $past(q_safe)));

  assert_safe_tracks_q_R5: assert property (@(posedge clk) disable iff (rst)
    in_ready |-> (q_safe == q));

  assert_count_bump_R8: assert property (@(posedge clk) disable iff (rst)
    (!in_ready && err_count != TOP) |=> (err_count == $past(err_count) + 1'b1));

  assert_count_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    in_ready |=> $stable(err_count));

  assert_reset_clear_R9: assert property (@(posedge clk)
    rst |=> (q == '0 && !err && err_count == '0));
endmodule

bind shadow_err_bank shadow_err_bank_chk #(.WIDTH(WIDTH), .CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .q         (q),
  .q_safe    (q_safe),
  .err       (err),
  .err_count (err_count)
);

// File: tb/shadow_err_bank_bench.sv
`timescale 1ns/100ps
module shadow_err_bank_bench;
  localparam int W  = 6;
  localparam int CW = 3;
  localparam int N  = 1 << W;
  localparam int CMAX = (1 << CW) - 1;

  logic          clk = 1'b0;
  logic          clk_del = 1'b0;
  logic          rst;
  logic          in_valid;
  logic          in_ready;
  logic [W-1:0]  in_data;
  logic [W-1:0]  q;
  logic [W-1:0]  q_safe;
  logic          err;
  logic [CW-1:0] err_count;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  shadow_err_bank #(.WIDTH(W), .CNT_W(CW)) u_shadow_err_bank (
    .clk(clk), .clk_del(clk_del), .rst(rst),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .q(q), .q_safe(q_safe), .err(err), .err_count(err_count)
  );

  // 125 MHz; delayed clock trails by 3 ns, so the shadow window is edge+3..edge+7.
  initial forever #4 clk = ~clk;
  always @(clk) clk_del <= #3 clk;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Return just after the shadow window closes: outputs settled, safe to drive.
  task automatic cyc();
    @(negedge clk_del);
    #0.2;
  endtask

  task automatic wrap_up();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(8 * 100000);
    chk(1'b0, "WD", "watchdog expired", 0, 1);
    wrap_up();
  end

  initial begin
    int expc;
    logic [W-1:0] hold;
    rst = 1'b1; in_valid = 1'b0; in_data = '0;
    cyc(); cyc();
    chk(q == 0, "R9", "q after reset", q, 0);
    chk(q_safe == 0, "R9", "q_safe after reset", q_safe, 0);
    chk(err == 0, "R9", "err after reset", err, 0);
    chk(err_count == 0, "R9", "count after reset", err_count, 0);
    chk(in_ready == 1, "R9", "ready after reset", in_ready, 1);
    rst = 1'b0;

    // Settled data, every value.
    for (int v = 0; v < N; v++) begin
      in_data = v[W-1:0]; in_valid = 1'b1;
      cyc();
      chk(q == v[W-1:0], "R1", "q after transfer", q, v);
      chk(err == 0, "R3", "err on settled data", err, 0);
      chk(in_ready == 1, "R3", "ready on settled data", in_ready, 1);
    end
    in_valid = 1'b0;
    cyc();
    chk(err == 0, "R3", "err after last settled", err, 0);
    chk(err_count == 0, "R3", "count after settled sweep", err_count, 0);

    // Idle with moving data, including inside the shadow window.
    hold = q;
    for (int k = 0; k < 8; k++) begin
      in_data = W'(k * 9);
      @(posedge clk); #1;
      in_data = ~in_data;
      cyc();
      chk(q == hold, "R2", "q held while idle", q, hold);
      chk(err == 0, "R2", "err while idle", err, 0);
    end

    // Late change after the capture edge, every starting value.
    expc = 0;
    for (int a = 0; a < N; a++) begin
      int b;
      b = (a * 5 + 3) % N;
      in_valid = 1'b1; in_data = a[W-1:0];
      @(posedge clk); #1;
      in_data = b[W-1:0];
      cyc();
      chk(q == a[W-1:0], "R1", "speculative q", q, a);
      chk(q_safe == b[W-1:0], "R5", "q_safe while pending", q_safe, b);
      chk(in_ready == 0, "R6", "ready while pending", in_ready, 0);
      chk(err == 0, "R4", "err before pulse", err, 0);
      cyc();
      expc = (expc < CMAX) ? expc + 1 : CMAX;
      chk(err == 1, "R4", "err pulse", err, 1);
      chk(q == b[W-1:0], "R7", "q corrected", q, b);
      chk(err_count == expc, "R8", "count", err_count, expc);
      chk(in_ready == 1, "R6", "ready after stall", in_ready, 1);
      chk(q_safe == q, "R5", "q_safe after correction", q_safe, q);
      cyc();
      chk(err == 0, "R4", "err single cycle", err, 0);
      chk(q == b[W-1:0], "R7", "q after replay", q, b);
    end

    // Reset mid-run.
    rst = 1'b1;
    cyc();
    chk(q == 0, "R9", "q after late reset", q, 0);
    chk(err_count == 0, "R9", "count after late reset", err_count, 0);
    chk(q_safe == 0, "R9", "q_safe after late reset", q_safe, 0);
    rst = 1'b0; in_valid = 1'b0;
    cyc();
    chk(err == 0, "R9", "err after late reset", err, 0);
    wrap_up();
  end
endmodule